// File: doc/BRIEF.md
# Hub Pointer Expression Address Unit

This block turns a 9-bit source-operand field into a memory address when that field holds a pointer expression on one of two 20-bit pointer registers, named A and B. The pointer can be read with a signed index and left unchanged. It can also be stepped up or down, with the address taken either after the step (pre-modify) or before it (post-modify). Index and step are scaled by the access size, so the same encoding moves by whole bytes, words or longs.

The unit is purely combinational. The caller supplies the field, the immediate flag, the access size and both current pointer values. In the same cycle the unit returns the pointer-mode flag, the effective address, which pointer is addressed, a write-enable and the value to store. The pointer register file outside the block commits that value on its next clock edge. When the field is not a pointer expression, the field is passed through unchanged as a plain address.

Top module: `hpx_ptr_unit`

## Requirements
- R1: Pointer mode is asserted only when the immediate flag is 1 and field bit 8 is 1. Otherwise pointer mode is 0, write-enable is 0, pointer select is 0, the address is the 9-bit field zero-extended to 20 bits, and the next-pointer output equals pointer A.
- R2: In pointer mode, field bit 7 chooses the pointer (0 = A, 1 = B). The pointer select output reports that choice.
- R3: With field bit 6 at 0 (indexed form), bits 5:0 are a two's-complement index from -32 to +31. The address is the pointer plus the scaled index. Write-enable is 0, and the next-pointer output equals the selected pointer unchanged.
- R4: With field bit 6 at 1 (update form), bits 4:0 give the step. A value of 0 means +16, values 1 to 15 are positive, and 0x10 to 0x1F are -16 to -1. Write-enable is 1, and the next-pointer output is the pointer plus the scaled step.
- R5: In the update form with field bit 5 at 0 (pre-modify), the address equals the new pointer value.
- R6: In the update form with field bit 5 at 1 (post-modify), the address equals the old pointer value.
- R7: The access size input scales the index or step: 2'b00 byte ×1, 2'b01 word ×2, 2'b10 long ×4, and 2'b11 is treated as long ×4.
- R8: All pointer arithmetic wraps modulo 2^20.
- R9: All outputs are a combinational function of the current inputs and are valid in the same cycle the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_i | input | 1 | Source operand is an immediate field |
| field_i | input | 9 | Source-operand field |
| size_i | input | 2 | Access size: 0 byte, 1 word, 2/3 long |
| ptr_a_i | input | 20 | Current value of pointer A |
| ptr_b_i | input | 20 | Current value of pointer B |
| ptr_mode_o | output | 1 | Field was decoded as a pointer expression |
| addr_o | output | 20 | Effective address, or the passed-through field |
| ptr_sel_o | output | 1 | Pointer addressed: 0 A, 1 B |
| ptr_we_o | output | 1 | Selected pointer is to be written back |
| ptr_next_o | output | 20 | Value to store into the selected pointer |

## Verification
The bench targets the step code 0. A design that sign-extends it literally would produce a zero step and leave the pointer unchanged, instead of moving it by sixteen units. It also checks the pre/post split, because swapping it returns the wrong one of the two addresses while the written-back value still looks right, and the index extremes -32 and +31, which break when the sign is taken from the wrong bit. Long and word scaling of negative steps, and pointers near zero and near the top of the 20-bit space, show up a missing sign extension or a carry into bit 20. Fields with bit 8 set but the immediate flag clear must still pass straight through with no write.

// File: rtl/hpx_pkg.sv
`timescale 1ns/1ps
package hpx_pkg;
    localparam int PTR_W   = 20;
    localparam int FIELD_W = 9;
    localparam int IDX_W   = 7;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic                    ptr_mode;
        logic                    sel;
        logic                    upd;
        logic                    post;
        logic signed [IDX_W-1:0] idx;
    } ptr_dec_t;

    typedef struct packed {
        logic [PTR_W-1:0] addr;
        logic             sel;
        logic             we;
        logic [PTR_W-1:0] nxt;
    } ptr_out_t;
endpackage

// File: rtl/hpx_field_decode.sv
`timescale 1ns/1ps
module hpx_field_decode
    import hpx_pkg::*;
(
    input  logic               imm_i,
    input  logic [FIELD_W-1:0] field_i,
    output ptr_dec_t           dec_o
);
    ptr_dec_t dec_d;

    always_comb begin
        dec_d = '0;
        dec_d.ptr_mode = imm_i & field_i[8];
        if (dec_d.ptr_mode) begin
            dec_d.sel = field_i[7];
            dec_d.upd = field_i[6];
            if (!field_i[6]) begin
                // indexed form: 6-bit signed index
                dec_d.idx = {field_i[5], field_i[5:0]};
            end else begin
                dec_d.post = field_i[5];
                // step code zero stands for +16
                if (field_i[4:0] == 5'd0)
                    dec_d.idx = 7'sd16;
                else
                    dec_d.idx = {{2{field_i[4]}}, field_i[4:0]};
            end
        end
    end

    assign dec_o = dec_d;

    // R4: an update step is never zero and stays within -16..+16
    always_comb begin
        if (dec_d.ptr_mode && dec_d.upd) begin
            assert_step_range_R4: assert (dec_d.idx != 7'sd0
                                          && dec_d.idx >= -7'sd16
                                          && dec_d.idx <= 7'sd16)
                else $error("update step out of range");
        end
    end
endmodule

// File: rtl/hpx_index_scale.sv
`timescale 1ns/1ps
module hpx_index_scale
    import hpx_pkg::*;
#(
    parameter int OUT_W = PTR_W,
    parameter int IN_W  = IDX_W
) (
    input  logic signed [IN_W-1:0] idx_i,
    input  logic [1:0]             size_i,
    output logic [OUT_W-1:0]       off_o
);
    localparam int EXT_W = OUT_W - IN_W;

    logic [OUT_W-1:0] ext_d;
    logic [OUT_W-1:0] off_d;

    always_comb begin
        ext_d = {{EXT_W{idx_i[IN_W-1]}}, idx_i};
        case (acc_size_e'(size_i))
            SZ_BYTE: off_d = ext_d;
            SZ_WORD: off_d = ext_d << 1;
            default: off_d = ext_d << 2;
        endcase
    end

    assign off_o = off_d;
endmodule

// File: rtl/hpx_addr_gen.sv
`timescale 1ns/1ps
module hpx_addr_gen
    import hpx_pkg::*;
(
    input  ptr_dec_t           dec_i,
    input  logic [PTR_W-1:0]   off_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [PTR_W-1:0]   ptr_a_i,
    input  logic [PTR_W-1:0]   ptr_b_i,
    output ptr_out_t           out_o
);
    ptr_out_t         out_d;
    logic [PTR_W-1:0] base_d;
    logic [PTR_W-1:0] sum_d;

    always_comb begin
        base_d = dec_i.sel ? ptr_b_i : ptr_a_i;
        sum_d  = base_d + off_i;
        out_d  = '0;
        if (!dec_i.ptr_mode) begin
            out_d.addr = {{(PTR_W-FIELD_W){1'b0}}, field_i};
            out_d.nxt  = ptr_a_i;
        end else if (!dec_i.upd) begin
            out_d.sel  = dec_i.sel;
            out_d.addr = sum_d;
            out_d.nxt  = base_d;
        end else begin
            out_d.sel  = dec_i.sel;
            out_d.we   = 1'b1;
            out_d.nxt  = sum_d;
            out_d.addr = dec_i.post ? base_d : sum_d;
        end
    end

    assign out_o = out_d;

    always_comb begin
        if (dec_i.ptr_mode && dec_i.upd && !dec_i.post) begin
            assert_pre_uses_new_R5: assert (out_d.addr == out_d.nxt)
                else $error("pre-modify address differs from new pointer");
        end
        if (dec_i.ptr_mode && dec_i.upd && dec_i.post) begin
            assert_post_uses_old_R6: assert (out_d.addr ==
                                             (dec_i.sel ? ptr_b_i : ptr_a_i))
                else $error("post-modify address differs from old pointer");
        end
    end
endmodule

// File: rtl/hpx_ptr_unit.sv
`timescale 1ns/1ps
module hpx_ptr_unit
    import hpx_pkg::*;
(
    input  logic               imm_i,
    input  logic [8:0]         field_i,
    input  logic [1:0]         size_i,
    input  logic [19:0]        ptr_a_i,
    input  logic [19:0]        ptr_b_i,
    output logic               ptr_mode_o,
    output logic [19:0]        addr_o,
    output logic               ptr_sel_o,
    output logic               ptr_we_o,
    output logic [19:0]        ptr_next_o
);
    ptr_dec_t         dec_q;
    logic [PTR_W-1:0] off_q;
    ptr_out_t         out_q;

    hpx_field_decode u_dec (
        .imm_i   (imm_i),
        .field_i (field_i),
        .dec_o   (dec_q)
    );

    hpx_index_scale #(.OUT_W(PTR_W), .IN_W(IDX_W)) u_scale (
        .idx_i  (dec_q.idx),
        .size_i (size_i),
        .off_o  (off_q)
    );

    hpx_addr_gen u_agen (
        .dec_i   (dec_q),
        .off_i   (off_q),
        .field_i (field_i),
        .ptr_a_i (ptr_a_i),
        .ptr_b_i (ptr_b_i),
        .out_o   (out_q)
    );

    assign ptr_mode_o = dec_q.ptr_mode;
    assign addr_o     = out_q.addr;
    assign ptr_sel_o  = out_q.sel;
    assign ptr_we_o   = out_q.we;
    assign ptr_next_o = out_q.nxt;

    always_comb begin
        if (!(imm_i && field_i[8])) begin
            assert_plain_pass_R1: assert (!ptr_we_o && !ptr_mode_o
                                          && addr_o == {11'b0, field_i}
                                          && ptr_next_o == ptr_a_i)
                else $error("plain operand not passed through");
        end else begin
            assert_select_R2: assert (ptr_sel_o == field_i[7])
                else $error("pointer select mismatch");
            if (!field_i[6]) begin
                assert_index_no_write_R3: assert (!ptr_we_o && ptr_next_o ==
                                                  (field_i[7] ? ptr_b_i : ptr_a_i))
                    else $error("indexed form altered pointer");
            end
        end
    end
endmodule

// File: tb/tb_hpx_ptr_unit.sv
`timescale 1ns/1ps
module tb_hpx_ptr_unit;
    logic        clk = 1'b0;
    logic        imm;
    logic [8:0]  field;
    logic [1:0]  size;
    logic [19:0] pa, pb;
    logic        mode, sel, we;
    logic [19:0] addr, nxt;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    hpx_ptr_unit dut (
        .imm_i(imm), .field_i(field), .size_i(size),
        .ptr_a_i(pa), .ptr_b_i(pb),
        .ptr_mode_o(mode), .addr_o(addr), .ptr_sel_o(sel),
        .ptr_we_o(we), .ptr_next_o(nxt)
    );

    // behavioural reference
    task automatic model(input logic i, input logic [8:0] f, input logic [1:0] s,
                         input logic [19:0] a, input logic [19:0] b,
                         output logic em, output logic [19:0] ea, output logic es,
                         output logic ew, output logic [19:0] en);
        int p, v, sc;
        if (!(i && f[8])) begin
            em = 0; es = 0; ew = 0; ea = {11'b0, f}; en = a;
        end else begin
            em = 1; es = f[7];
            p  = f[7] ? int'(b) : int'(a);
            sc = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
            if (!f[6]) begin
                v = int'(f[5:0]);
                if (v >= 32) v = v - 64;
                ea = 20'((p + v * sc) & 32'hFFFFF);
                ew = 0; en = 20'(p);
            end else begin
                v = int'(f[4:0]);
                if (v == 0) v = 16;
                else if (v >= 16) v = v - 32;
                en = 20'((p + v * sc) & 32'hFFFFF);
                ew = 1;
                ea = f[5] ? 20'(p) : en;
            end
        end
    endtask

    task automatic apply(input logic i, input logic [8:0] f, input logic [1:0] s,
                         input logic [19:0] a, input logic [19:0] b, input string tag);
        logic em, es, ew;
        logic [19:0] ea, en;
        @(posedge clk);
        #1;
        imm = i; field = f; size = s; pa = a; pb = b;
        model(i, f, s, a, b, em, ea, es, ew, en);
        @(negedge clk);   // same cycle as the inputs (R9)
        checks++;
        if (mode !== em || addr !== ea || sel !== es || we !== ew || nxt !== en) begin
            fails++;
            $display("FAIL %s field=%h imm=%b size=%0d: got mode=%b addr=%h sel=%b we=%b next=%h, expected mode=%b addr=%h sel=%b we=%b next=%h",
                     tag, f, i, s, mode, addr, sel, we, nxt, em, ea, es, ew, en);
        end
    endtask

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        imm = 0; field = 0; size = 0; pa = 0; pb = 0;
        // idle state, no pointer expression (R1)
        apply(1'b0, 9'h000, 2'd0, 20'h0, 20'h0, "R1 idle");
        apply(1'b0, 9'h141, 2'd2, 20'h00100, 20'h00200, "R1 imm clear");
        apply(1'b1, 9'h0E1, 2'd2, 20'h00100, 20'h00200, "R1 bit8 clear");
        // indexed form (R3) and select (R2)
        apply(1'b1, 9'h100, 2'd0, 20'h01000, 20'h02000, "R3 plain A");
        apply(1'b1, 9'h180, 2'd0, 20'h01000, 20'h02000, "R2 plain B");
        apply(1'b1, 9'h13F, 2'd0, 20'h01000, 20'h02000, "R3 index -1");
        apply(1'b1, 9'h120, 2'd2, 20'h01000, 20'h02000, "R3 index -32 long");
        apply(1'b1, 9'h11F, 2'd1, 20'h01000, 20'h02000, "R3 index +31 word");
        // update forms
        apply(1'b1, 9'h141, 2'd2, 20'h01000, 20'h02000, "R5 pre-inc A");
        apply(1'b1, 9'h15F, 2'd2, 20'h01000, 20'h02000, "R5 pre-dec A");
        apply(1'b1, 9'h161, 2'd2, 20'h01000, 20'h02000, "R6 post-inc A");
        apply(1'b1, 9'h17F, 2'd0, 20'h01000, 20'h02000, "R6 post-dec A");
        apply(1'b1, 9'h1E1, 2'd1, 20'h01000, 20'h02000, "R2 post-inc B");
        apply(1'b1, 9'h140, 2'd0, 20'h01000, 20'h02000, "R4 step code 0 is +16");
        apply(1'b1, 9'h170, 2'd2, 20'h01000, 20'h02000, "R4 step -16 long");
        apply(1'b1, 9'h14F, 2'd3, 20'h01000, 20'h02000, "R7 step +15 size 3");
        apply(1'b1, 9'h1C0, 2'd1, 20'h01000, 20'h02000, "R7 B step +16 word");
        // wrap-around
        apply(1'b1, 9'h15F, 2'd2, 20'h00000, 20'h02000, "R8 wrap below zero");
        apply(1'b1, 9'h1C0, 2'd2, 20'h02000, 20'hFFFF8, "R8 wrap above top");
        apply(1'b1, 9'h120, 2'd2, 20'h00010, 20'h02000, "R8 index wraps");
        // mixed patterns
        for (int k = 0; k < 400; k++) begin
            logic       ri;
            logic [8:0] rf;
            string      t;
            ri = ($urandom % 4) != 0;
            rf = 9'($urandom);
            if (!(ri && rf[8]))   t = "R1 random";
            else if (!rf[6])      t = "R3 random";
            else if (rf[5])       t = "R6 random";
            else                  t = "R5 random";
            apply(ri, rf, 2'($urandom), 20'($urandom), 20'($urandom), t);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule